// File: doc/BRIEF.md
# Word-Mark-Terminated Field Move Engine

This engine copies a variable-length field between two areas of a character-serial store. Every storage word holds a 6-bit character and a word-mark bit. The caller supplies a source (A) address, a destination (B) address and the length code of the instruction that asked for the move. The engine then works from the low-order (rightmost) end toward the left. For each character it reads the A location and writes the whole word, mark included, to the B location, and after each access it decrements the address it used. The move ends with the first A character that carries a word mark. Because the field's length comes from that mark, the destination ends up with exactly the source's mark pattern over the span it wrote. Destination words to the left of that span are never touched.

The engine drives a synchronous single-port memory whose read data arrives one clock after the request. It runs in one of two modes. In free-running mode it performs back-to-back read/write pairs. In single-cycle mode it performs one memory cycle for each step request and holds the fetched character between steps. When the move ends, the engine pulses `done` and presents the final A and B register values. An illegal length code, an address outside the store, or a corrupted control state ends the operation with an error code. For an address fault, the engine also reports whether the A side or the B side faulted.

Top module: `wm_field_mover`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `mem_en` are all low.
- R2: A start whose `len_code` is not 1, 4 or 7 performs no memory access. In that case `done` pulses in the clock after the start, with `err`=1 and `err_code`=1.
- R3: For every location moved, the destination receives the source character and its word-mark bit (bit 6 of the word; bits 5:0 are the character). Destination marks are therefore cleared everywhere the source had none.
- R4: The move ends after it writes the first A word whose mark is set. Destination words to the left of the last one written keep their old contents, their own word marks included.
- R5: When the move ends, `a_final` and `b_final` hold the address one below the last location read and the last location written, with 14-bit wrap-around below zero.
- R6: An A address outside 0..MEM_WORDS-1 at a read cycle ends the operation without that read. `err`=1, `err_code`=2, `fault_b`=0, and `a_final` holds the faulting address.
- R7: A B address outside the store at a write cycle ends the operation without that write. `err`=1, `err_code`=2, `fault_b`=1. The fault takes priority over a word mark on the character that was waiting to be written.
- R8: In free-running mode, each character costs one read cycle followed by one write cycle. `done` goes high 2n clocks after the start edge for n characters and stays high for exactly one clock.
- R9: In single-cycle mode, no memory access happens in a cycle without `step`. Each step performs exactly one access, and a move of n characters ends after 2n steps with the same memory result as free-running mode.
- R10: `err`, `err_code` and `fault_b` hold their values after `done` until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled while idle) |
| len_code | input | 3 | Instruction length code |
| a_start | input | 14 | Rightmost source address |
| b_start | input | 14 | Rightmost destination address |
| step_mode | input | 1 | 1 = one memory cycle per step request |
| step | input | 1 | Step request in single-cycle mode |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 14 | Memory address |
| mem_wdata | output | 7 | Write word {mark, char} |
| mem_rdata | input | 7 | Read word, valid one clock after a read request |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | Last operation ended in error |
| err_code | output | 2 | 0 none, 1 illegal length, 2 address fault, 3 bad control state |
| fault_b | output | 1 | Address fault occurred on the B side |
| a_final | output | 14 | Current / final A address register |
| b_final | output | 14 | Current / final B address register |

## Verification
Two functions can fall in the same write cycle: the word-mark stop and the B-side range check. The bench provokes this with a one-character A field whose only word has a mark, aimed at a B address past the end of the store. It also uses a B field that starts at zero and wraps out of range mid-move. The case passes only if the fault wins: no write takes place, `fault_b` is set, and the store matches a reference that applies the range check before the write.

// File: rtl/wfm_pkg.sv
package wfm_pkg;

    localparam int CHAR_W = 6;
    localparam int WORD_W = CHAR_W + 1;

    typedef struct packed {
        logic              mark;
        logic [CHAR_W-1:0] ch;
    } word_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READ  = 3'd1,
        ST_WRITE = 3'd2
    } state_t;

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_LEN   = 2'd1,
        ERR_ADDR  = 2'd2,
        ERR_STATE = 2'd3
    } err_t;

    // Lengths accepted for a move: chained, one-address, two-address.
    function automatic logic legal_len(input logic [2:0] len);
        return (len == 3'd1) || (len == 3'd4) || (len == 3'd7);
    endfunction

endpackage

// File: rtl/wfm_addr_reg.sv
module wfm_addr_reg
    import wfm_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int MEM_WORDS = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              dec,
    output logic [ADDR_W-1:0] value,
    output logic              in_range
);
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(MEM_WORDS);

    logic [ADDR_W-1:0] r_q;

    always_ff @(posedge clk) begin
        if (rst)
            r_q <= '0;
        else if (load)
            r_q <= load_val;
        else if (dec)
            r_q <= r_q - 1'b1;
    end

    assign value    = r_q;
    assign in_range = ({1'b0, r_q} < LIMIT);
endmodule

// File: rtl/wfm_data_hold.sv
module wfm_data_hold
    import wfm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_issue,
    input  word_t rdata,
    output word_t cur
);
    logic  pend_q;
    word_t held_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            held_q <= '0;
        end else begin
            pend_q <= rd_issue;
            if (pend_q)
                held_q <= rdata;
        end
    end

    // Fresh data is on the bus only in the clock right after the read.
    assign cur = pend_q ? rdata : held_q;
endmodule

// File: rtl/wfm_ctrl.sv
module wfm_ctrl
    import wfm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic [2:0] len_code,
    input  logic       step_mode,
    input  logic       step,
    input  logic       a_ok,
    input  logic       b_ok,
    input  logic       cur_mark,
    output logic       load,
    output logic       rd_en,
    output logic       wr_en,
    output logic       busy,
    output logic       done,
    output logic       err,
    output err_t       err_code,
    output logic       fault_b
);
    state_t state_q, state_n;
    logic   go, fin, abort, fb_n;
    err_t   code_n;

    assign go    = !step_mode || step;
    assign busy  = (state_q != ST_IDLE);
    assign load  = (state_q == ST_IDLE) && start && legal_len(len_code);
    assign rd_en = (state_q == ST_READ)  && go && a_ok;
    assign wr_en = (state_q == ST_WRITE) && go && b_ok;

    always_comb begin
        state_n = state_q;
        fin     = 1'b0;
        abort   = 1'b0;
        code_n  = ERR_NONE;
        fb_n    = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (legal_len(len_code)) begin
                        state_n = ST_READ;
                    end else begin
                        fin    = 1'b1;
                        abort  = 1'b1;
                        code_n = ERR_LEN;
                    end
                end
            end
            ST_READ: begin
                if (go) begin
                    if (a_ok) begin
                        state_n = ST_WRITE;
                    end else begin
                        state_n = ST_IDLE;
                        fin     = 1'b1;
                        abort   = 1'b1;
                        code_n  = ERR_ADDR;
                    end
                end
            end
            ST_WRITE: begin
                if (go) begin
                    if (!b_ok) begin
                        state_n = ST_IDLE;
                        fin     = 1'b1;
                        abort   = 1'b1;
                        code_n  = ERR_ADDR;
                        fb_n    = 1'b1;
                    end else if (cur_mark) begin
                        state_n = ST_IDLE;
                        fin     = 1'b1;
                    end else begin
                        state_n = ST_READ;
                    end
                end
            end
            default: begin
                state_n = ST_IDLE;
                fin     = 1'b1;
                abort   = 1'b1;
                code_n  = ERR_STATE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= ERR_NONE;
            fault_b  <= 1'b0;
        end else begin
            state_q <= state_n;
            done    <= fin;
            if (abort) begin
                err      <= 1'b1;
                err_code <= code_n;
                fault_b  <= fb_n;
            end else if (load) begin
                err      <= 1'b0;
                err_code <= ERR_NONE;
                fault_b  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/wm_field_mover.sv
module wm_field_mover
    import wfm_pkg::*;
#(
    parameter int ADDR_W    = 14,
    parameter int MEM_WORDS = 2000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [2:0]        len_code,
    input  logic [ADDR_W-1:0] a_start,
    input  logic [ADDR_W-1:0] b_start,
    input  logic              step_mode,
    input  logic              step,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic              fault_b,
    output logic [ADDR_W-1:0] a_final,
    output logic [ADDR_W-1:0] b_final
);
    localparam int SIDE_A = 0;
    localparam int SIDE_B = 1;

    logic              load, rd_en, wr_en;
    logic [ADDR_W-1:0] start_val [2];
    logic [ADDR_W-1:0] addr_q    [2];
    logic              ok        [2];
    logic              dec       [2];
    word_t             cur_word;
    err_t              code_e;

    assign start_val[SIDE_A] = a_start;
    assign start_val[SIDE_B] = b_start;
    assign dec[SIDE_A]       = rd_en;
    assign dec[SIDE_B]       = wr_en;

    for (genvar g = 0; g < 2; g++) begin : g_side
        wfm_addr_reg #(
            .ADDR_W   (ADDR_W),
            .MEM_WORDS(MEM_WORDS)
        ) u_reg (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .load_val(start_val[g]),
            .dec     (dec[g]),
            .value   (addr_q[g]),
            .in_range(ok[g])
        );
    end

    wfm_data_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .rd_issue(rd_en),
        .rdata   (word_t'(mem_rdata)),
        .cur     (cur_word)
    );

    wfm_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .len_code (len_code),
        .step_mode(step_mode),
        .step     (step),
        .a_ok     (ok[SIDE_A]),
        .b_ok     (ok[SIDE_B]),
        .cur_mark (cur_word.mark),
        .load     (load),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .err_code (code_e),
        .fault_b  (fault_b)
    );

    assign mem_en    = rd_en || wr_en;
    assign mem_we    = wr_en;
    assign mem_addr  = wr_en ? addr_q[SIDE_B] : addr_q[SIDE_A];
    assign mem_wdata = cur_word;
    assign err_code  = code_e;
    assign a_final   = addr_q[SIDE_A];
    assign b_final   = addr_q[SIDE_B];
endmodule

// File: rtl/wfm_checker.sv
module wfm_checker #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic              step_mode,
    input logic              step,
    input logic              mem_en,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [6:0]        mem_wdata,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [ADDR_W-1:0] a_final
);
    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!busy && !done));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    step_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (step_mode && !step) |-> !mem_en);

    // R4
    mark_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_wdata[6]) |=> (done && !err && !busy));

    // R5
    a_step_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |=> (a_final == $past(mem_addr) - 1'b1));

    // R8
    read_before_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && !step_mode) |-> $past(mem_en && !mem_we));

    // R3
    write_enabled_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> mem_en);
endmodule

bind wm_field_mover wfm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step_mode(step_mode),
    .step     (step),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .busy     (busy),
    .done     (done),
    .err      (err),
    .a_final  (a_final)
);

// File: tb/tb_wm_field_mover.sv
module tb_wm_field_mover;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 2000;
    localparam int AW         = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [2:0]    len_code = 3'd7;
    logic [AW-1:0] a_start = '0, b_start = '0;
    logic          step_mode = 1'b0, step = 1'b0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [6:0]    mem_wdata;
    logic [6:0]    mem_rdata = '0;
    logic          busy, done, err, fault_b;
    logic [1:0]    err_code;
    logic [AW-1:0] a_final, b_final;

    logic [6:0] mem  [N];
    logic [6:0] rmem [N];
    int checks = 0, errors = 0;
    int acc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wm_field_mover #(.ADDR_W(AW), .MEM_WORDS(N)) dut (
        .clk(clk), .rst(rst), .start(start), .len_code(len_code),
        .a_start(a_start), .b_start(b_start), .step_mode(step_mode), .step(step),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .done(done),
        .err(err), .err_code(err_code), .fault_b(fault_b),
        .a_final(a_final), .b_final(b_final)
    );

    // Synchronous store, one-clock read latency
    always @(posedge clk) begin
        if (mem_en) begin
            acc <= acc + 1;
            if (int'(mem_addr) < N) begin
                if (mem_we) mem[mem_addr] <= mem_wdata;
                else        mem_rdata     <= mem[mem_addr];
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic fill_mem();
        for (int i = 0; i < N; i++)
            mem[i] = {($urandom % 8 == 0), 6'($urandom)};
    endtask

    // Source field of n words ending (leftmost) with a marked word
    task automatic place_field(input int a, input int n);
        for (int k = 0; k < n; k++)
            if (a - k >= 0) mem[a - k][6] = (k == n - 1);
    endtask

    task automatic snap();
        for (int i = 0; i < N; i++) rmem[i] = mem[i];
    endtask

    // Reference: range check, read A, range check, write B, stop on mark
    task automatic ref_move(input int a0, input int b0, output int ra, output int rb,
                            output int rcode, output int rfb, output int rn);
        int a, b;
        logic [6:0] w;
        a = a0; b = b0; rcode = 0; rfb = 0; rn = 0;
        for (int it = 0; it < N + 4; it++) begin
            if (a >= N) begin rcode = 2; break; end
            w = rmem[a];
            a = (a - 1) & 16'h3FFF;
            if (b >= N) begin rcode = 2; rfb = 1; break; end
            rmem[b] = w;
            b = (b - 1) & 16'h3FFF;
            rn++;
            if (w[6]) break;
        end
        ra = a; rb = b;
    endtask

    task automatic run_op(input int a, input int b, input logic [2:0] len,
                          input bit smode, input string tag);
        int ra, rb, rcode, rfb, rn, cyc, steps, bad;
        bit legal;
        legal = (len == 1) || (len == 4) || (len == 7);
        snap();
        if (legal) ref_move(a, b, ra, rb, rcode, rfb, rn);
        else begin rcode = 1; rfb = 0; rn = 0; end
        @(negedge clk);
        a_start = AW'(a); b_start = AW'(b); len_code = len;
        step_mode = smode; step = 1'b0; start = 1'b1;
        acc = 0;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; steps = 0;
        if (smode && legal) begin
            repeat (4) @(negedge clk);
            cyc += 4;
            chk(acc == 0, "R9", {tag, " access without step"}, acc, 0);
        end
        while (!done && cyc < 20000) begin
            if (smode) begin
                step = ((cyc % 3) == 2);
                if (step) steps++;
            end
            @(negedge clk);
            step = 1'b0;
            cyc++;
        end
        chk(done, "R8", {tag, " done seen"}, done, 1);
        chk(err == (rcode != 0), "R6", {tag, " err"}, err, rcode != 0);
        chk(int'(err_code) == rcode, rcode == 1 ? "R2" : "R6", {tag, " err_code"},
            err_code, rcode);
        chk(fault_b == rfb, "R7", {tag, " fault_b"}, fault_b, rfb);
        if (legal) begin
            chk(int'(a_final) == ra, "R5", {tag, " a_final"}, a_final, ra);
            chk(int'(b_final) == rb, "R5", {tag, " b_final"}, b_final, rb);
        end
        if (!smode && rcode == 0)
            chk(cyc == 2 * rn, "R8", {tag, " cycles"}, cyc, 2 * rn);
        if (smode && rcode == 0) begin
            chk(acc == 2 * rn, "R9", {tag, " accesses"}, acc, 2 * rn);
            chk(steps == 2 * rn, "R9", {tag, " steps"}, steps, 2 * rn);
        end
        if (!legal)
            chk(acc == 0, "R2", {tag, " accesses"}, acc, 0);
        bad = 0;
        for (int i = 0; i < N; i++) if (mem[i] !== rmem[i]) bad++;
        chk(bad == 0, "R3", {tag, " store mismatches (R4)"}, bad, 0);
        @(negedge clk);
        chk(!done, "R8", {tag, " done width"}, done, 0);
        chk(err == (rcode != 0), "R10", {tag, " err held"}, err, rcode != 0);
    endtask

    initial begin
        int n, a, b;
        logic [2:0] ln;
        void'($urandom(32'd4242));
        fill_mem();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !done && !err && !mem_en, "R1", "reset state",
            {busy, done, err, mem_en}, 0);

        // Basic moves with each legal length
        place_field(100, 5);  run_op(100, 300, 3'd7, 1'b0, "R3 basic");
        place_field(150, 3);  run_op(150, 400, 3'd1, 1'b0, "R3 chained");
        place_field(180, 1);  run_op(180, 500, 3'd4, 1'b0, "R8 single char");
        // Illegal lengths
        run_op(100, 300, 3'd3, 1'b0, "R2 len3");
        run_op(100, 300, 3'd0, 1'b0, "R2 len0");
        // B field longer than A: its own mark to the left survives
        mem[598][6] = 1'b1; mem[596][6] = 1'b1;
        place_field(220, 3);  run_op(220, 600, 3'd7, 1'b0, "R4 B longer");
        // A longer than B: B mark gets overwritten by cleared word
        mem[708][6] = 1'b1;
        place_field(260, 6);  run_op(260, 710, 3'd7, 1'b0, "R3 A longer");
        // A runs off the low end of the store
        mem[1][6] = 1'b0; mem[0][6] = 1'b0;
        run_op(1, 800, 3'd7, 1'b0, "R6 A wrap");
        // B out of range while the marked char is pending
        place_field(50, 1);  run_op(50, N + 5, 3'd7, 1'b0, "R7 B over mark");
        place_field(60, 4);  run_op(60, 0, 3'd7, 1'b0, "R7 B wrap");
        // A out of range from the start
        run_op(N + 3, 10, 3'd4, 1'b0, "R6 A high");
        // Single-cycle mode
        place_field(330, 4);  run_op(330, 900, 3'd7, 1'b1, "R9 step");
        // Overlap: destination one right of source
        place_field(40, 6);  run_op(40, 41, 3'd7, 1'b0, "R3 overlap");

        for (int t = 0; t < 30; t++) begin
            fill_mem();
            n  = 1 + ($urandom % 12);
            a  = n + ($urandom % (N - n));
            b  = ($urandom % (N + 40));
            ln = ($urandom % 6 == 0) ? 3'($urandom) : ((t % 3 == 0) ? 3'd1 : (t % 3 == 1) ? 3'd4 : 3'd7);
            place_field(a, n);
            run_op(a, b, ln, ($urandom % 4 == 0), "R3 random");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 190000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule